// File: doc/BRIEF.md
# DAC Output Conditioning Stage

This block sits between a waveform generator and a parallel DAC. It takes a signed two's-complement sample with a valid strobe and turns it into a word the converter can use. The sample is first multiplied by an amplitude factor in Q1.15. A signed DC bias is added to the scaled value, and the sum is clamped to the signed range of the sample width. The polarity can then be negated, again with clamping. The result can optionally be cut to a narrower converter width, with rounding, and placed at the top of the bus. Finally it is coded as offset binary or two's complement.

While the output is disabled, the bus holds the mid-scale code of the selected coding. The stage is a fixed three-register pipeline. All configuration inputs are captured in the same cycle as the sample they go with. A configuration change therefore applies only to samples that enter after it, and two samples in flight never mix settings. The valid strobe is delayed by the same three cycles.

Top module: `dac_out_shaper`

## Requirements
- R1: After a clock edge with `rst` high, `dac_data` is 0 and `dac_valid` is 0.
- R2: `dac_data` and `dac_valid` reflect the inputs sampled three rising edges earlier, so `dac_valid` is `smp_valid` delayed by exactly three cycles.
- R3: The scaled value is floor(sample × scale / 32768). Any `amp_scale` above 0x8000 acts as 0x8000 (unity).
- R4: The signed `dc_offset` is added to the scaled value, and the sum saturates to the range -8192 to 8191.
- R5: With `amp_scale` = 0 and the output enabled, the output is a constant level equal to `dc_offset` in the selected coding.
- R6: With `out_invert` = 1, the biased value is negated after the offset is added, and -8192 maps to +8191.
- R7: With `out_narrow` = 1, the value v becomes r = floor((v + 2) / 4), clamped to at most 2047. r is placed in bits 13:2 and bits 1:0 are 0. With `out_narrow` = 0, all 14 bits pass through.
- R8: With `out_offbin` = 1, the output is the two's-complement word with bit 13 flipped (offset binary). With `out_offbin` = 0, it is the two's-complement word itself.
- R9: With `out_enable` = 0, the output is the mid-scale code: 0x2000 in offset binary, 0x0000 in two's complement.
- R10: The configuration inputs are taken together with the sample in the same cycle. Changing the configuration every cycle gives each sample its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 14 | Signed input sample |
| amp_scale | input | 16 | Amplitude factor, Q1.15, unity = 0x8000 |
| dc_offset | input | 14 | Signed DC bias |
| out_enable | input | 1 | 1 = pass the signal, 0 = mid-scale idle |
| out_invert | input | 1 | 1 = negate polarity |
| out_narrow | input | 1 | 1 = round to 12 bits, MSB-aligned |
| out_offbin | input | 1 | 1 = offset binary, 0 = two's complement |
| dac_data | output | 14 | DAC code |
| dac_valid | output | 1 | Output strobe, three cycles after input |

## Verification
Offset saturation and polarity inversion can act on the same sample. The same holds for inversion and the 12-bit rounding overflow. The hardest case is a full-scale negative sample with the most negative bias. The sum clamps at -8192, inversion must turn it into +8191, and 12-bit rounding of that value overflows and must clamp to 0x1FFC. Directed vectors provoke this chain in both codings. Random traffic with settings that change every cycle then mixes it with everything else. The output is compared on every clock with a behavioural model that keeps the three-cycle delay in a queue.

// File: rtl/dacsh_pkg.sv
package dacsh_pkg;

    // Per-sample output settings, carried through the pipeline with the data
    typedef struct packed {
        logic en;      // 1: signal path, 0: mid-scale idle
        logic inv;     // polarity negate
        logic narrow;  // reduce to the narrow converter width
        logic offbin;  // 1: offset binary coding
    } dacsh_mode_t;

    typedef enum logic {
        CODE_TWOS   = 1'b0,
        CODE_OFFBIN = 1'b1
    } dacsh_code_e;

    function automatic dacsh_code_e dacsh_code_of(input dacsh_mode_t m);
        return m.offbin ? CODE_OFFBIN : CODE_TWOS;
    endfunction

    function automatic dacsh_mode_t dacsh_idle_mode();
        dacsh_mode_t m;
        m = '0;
        return m;
    endfunction

endpackage

// File: rtl/dacsh_scale.sv
module dacsh_scale
    import dacsh_pkg::*;
#(
    parameter int DW = 14,
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_smp,
    input  logic        [SW-1:0] in_scale,
    input  logic signed [DW-1:0] in_off,
    input  dacsh_mode_t          in_mode,
    output logic                 q_vld,
    output logic signed [DW-1:0] q_val,
    output logic signed [DW-1:0] q_off,
    output dacsh_mode_t          q_mode
);
    localparam int PW = DW + SW + 1;
    localparam logic [SW-1:0] UNITY = {1'b1, {(SW-1){1'b0}}};

    logic        [SW-1:0] scale_clip;
    logic signed [PW-1:0] prod;
    logic signed [DW-1:0] scaled;

    always_comb begin
        scale_clip = (in_scale > UNITY) ? UNITY : in_scale;
        prod       = $signed(in_smp) * $signed({1'b0, scale_clip});
        // floor division by 2^(SW-1): magnitude never exceeds the input
        scaled     = prod[SW-1 +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_val  <= '0;
            q_off  <= '0;
            q_mode <= dacsh_idle_mode();
        end else begin
            q_vld  <= in_vld;
            q_val  <= scaled;
            q_off  <= in_off;
            q_mode <= in_mode;
        end
    end

endmodule

// File: rtl/dacsh_bias.sv
module dacsh_bias
    import dacsh_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_val,
    input  logic signed [DW-1:0] in_off,
    input  dacsh_mode_t          in_mode,
    output logic                 q_vld,
    output logic signed [DW-1:0] q_val,
    output dacsh_mode_t          q_mode
);
    localparam logic signed [DW:0] VMAX = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [DW:0] VMIN = {2'b11, {(DW-1){1'b0}}};

    logic signed [DW:0]   sum_w;
    logic signed [DW-1:0] sum_sat;
    logic signed [DW:0]   neg_w;
    logic signed [DW-1:0] pol;

    always_comb begin
        sum_w = {in_val[DW-1], in_val} + {in_off[DW-1], in_off};
        if (sum_w > VMAX)      sum_sat = VMAX[DW-1:0];
        else if (sum_w < VMIN) sum_sat = VMIN[DW-1:0];
        else                   sum_sat = sum_w[DW-1:0];

        neg_w = -{sum_sat[DW-1], sum_sat};
        if (!in_mode.inv)      pol = sum_sat;
        else if (neg_w > VMAX) pol = VMAX[DW-1:0];
        else                   pol = neg_w[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_val  <= '0;
            q_mode <= dacsh_idle_mode();
        end else begin
            q_vld  <= in_vld;
            q_val  <= pol;
            q_mode <= in_mode;
        end
    end

endmodule

// File: rtl/dacsh_format.sv
module dacsh_format
    import dacsh_pkg::*;
#(
    parameter int DW = 14,
    parameter int NW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_val,
    input  dacsh_mode_t          in_mode,
    output logic                 q_vld,
    output logic        [DW-1:0] q_code
);
    localparam int DROP = DW - NW;

    logic signed [DW-1:0] reduced;
    logic        [DW-1:0] code;

    generate
        if (DROP > 0) begin : g_round
            localparam logic signed [DW:0] HALF = {{DW{1'b0}}, 1'b1} << (DROP - 1);
            localparam logic signed [DW:0] NMAX = {{(DROP+2){1'b0}}, {(NW-1){1'b1}}};
            logic signed [DW:0] ext;
            logic signed [DW:0] shr;
            always_comb begin
                ext = {in_val[DW-1], in_val} + HALF;
                shr = ext >>> DROP;
                if (!in_mode.narrow)  reduced = in_val;
                else if (shr > NMAX)  reduced = {NMAX[NW-1:0], {DROP{1'b0}}};
                else                  reduced = {shr[NW-1:0], {DROP{1'b0}}};
            end
        end else begin : g_full
            assign reduced = in_val;
        end
    endgenerate

    always_comb begin
        code = in_mode.en ? reduced : '0;
        if (dacsh_code_of(in_mode) == CODE_OFFBIN)
            code[DW-1] = ~code[DW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_code <= '0;
        end else begin
            q_vld  <= in_vld;
            q_code <= code;
        end
    end

endmodule

// File: rtl/dac_out_shaper.sv
module dac_out_shaper
    import dacsh_pkg::*;
#(
    parameter int DW = 14,
    parameter int SW = 16,
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic [SW-1:0] amp_scale,
    input  logic [DW-1:0] dc_offset,
    input  logic          out_enable,
    input  logic          out_invert,
    input  logic          out_narrow,
    input  logic          out_offbin,
    output logic [DW-1:0] dac_data,
    output logic          dac_valid
);
    dacsh_mode_t          mode_in;
    logic                 s1_vld, s2_vld;
    logic signed [DW-1:0] s1_val, s1_off, s2_val;
    dacsh_mode_t          s1_mode, s2_mode;

    always_comb begin
        mode_in.en     = out_enable;
        mode_in.inv    = out_invert;
        mode_in.narrow = out_narrow;
        mode_in.offbin = out_offbin;
    end

    dacsh_scale #(.DW(DW), .SW(SW)) u_scale (
        .clk(clk), .rst(rst),
        .in_vld(smp_valid), .in_smp($signed(smp_data)), .in_scale(amp_scale),
        .in_off($signed(dc_offset)), .in_mode(mode_in),
        .q_vld(s1_vld), .q_val(s1_val), .q_off(s1_off), .q_mode(s1_mode)
    );

    dacsh_bias #(.DW(DW)) u_bias (
        .clk(clk), .rst(rst),
        .in_vld(s1_vld), .in_val(s1_val), .in_off(s1_off), .in_mode(s1_mode),
        .q_vld(s2_vld), .q_val(s2_val), .q_mode(s2_mode)
    );

    dacsh_format #(.DW(DW), .NW(NW)) u_format (
        .clk(clk), .rst(rst),
        .in_vld(s2_vld), .in_val(s2_val), .in_mode(s2_mode),
        .q_vld(dac_valid), .q_code(dac_data)
    );

endmodule

// File: rtl/dacsh_checker.sv
module dacsh_checker #(
    parameter int DW = 14,
    parameter int SW = 16,
    parameter int NW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_valid,
    input logic [SW-1:0] amp_scale,
    input logic [DW-1:0] dc_offset,
    input logic          out_enable,
    input logic          out_invert,
    input logic          out_narrow,
    input logic          out_offbin,
    input logic [DW-1:0] dac_data,
    input logic          dac_valid
);
    localparam int DROP = DW - NW;
    localparam logic [DW-1:0] MSB = {1'b1, {(DW-1){1'b0}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: reset clears the output word and strobe
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (dac_data == '0 && dac_valid == 1'b0));

    // R2: strobe delayed by exactly three cycles
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        since_rst == 2'd3 |-> dac_valid == $past(smp_valid, 3));

    // R9: idle code while disabled
    p_midscale_r9: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && !$past(out_enable, 3)) |->
            dac_data == ($past(out_offbin, 3) ? MSB : '0));

    // R5: zero amplitude leaves only the bias
    p_pure_dc_r5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(amp_scale == '0 && out_enable && !out_invert && !out_narrow, 3)) |->
            dac_data == ($past(dc_offset, 3) ^ ($past(out_offbin, 3) ? MSB : '0)));

    // R7: low bits vanish in narrow mode
    generate
        if (DROP > 0) begin : g_lsb
            p_narrow_lsb_r7: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3 && $past(out_narrow, 3)) |-> dac_data[DROP-1:0] == '0);
        end
    endgenerate

endmodule

bind dac_out_shaper dacsh_checker #(.DW(DW), .SW(SW), .NW(NW)) u_dacsh_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .amp_scale(amp_scale),
    .dc_offset(dc_offset), .out_enable(out_enable), .out_invert(out_invert),
    .out_narrow(out_narrow), .out_offbin(out_offbin),
    .dac_data(dac_data), .dac_valid(dac_valid)
);

// File: tb/tb_dac_out_shaper.sv
module tb_dac_out_shaper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_data = '0;
    logic [15:0] amp_scale = '0;
    logic [13:0] dc_offset = '0;
    logic        out_enable = 1'b0, out_invert = 1'b0, out_narrow = 1'b0, out_offbin = 1'b0;
    logic [13:0] dac_data;
    logic        dac_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_tag = 1;
    bit done = 1'b0;

    typedef struct {
        int smp; int scl; int off;
        bit en; bit inv; bit nar; bit ob; bit vld;
        int tag;
    } ent_t;
    ent_t hist[$];

    always #10 clk = ~clk;

    dac_out_shaper dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .amp_scale(amp_scale), .dc_offset(dc_offset), .out_enable(out_enable),
        .out_invert(out_invert), .out_narrow(out_narrow), .out_offbin(out_offbin),
        .dac_data(dac_data), .dac_valid(dac_valid)
    );

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int model_code(input ent_t e);
        int sc, v, r, c;
        sc = (e.scl > 32768) ? 32768 : e.scl;
        v  = (e.smp * sc) >>> 15;
        v  = clampi(v + e.off, -8192, 8191);
        if (e.inv) v = clampi(-v, -8192, 8191);
        if (e.nar) begin
            r = (v + 2) >>> 2;
            if (r > 2047) r = 2047;
            v = r * 4;
        end
        if (!e.en) v = 0;
        c = v & 'h3FFF;
        if (e.ob) c = c ^ 'h2000;
        return c;
    endfunction

    // reference pipeline: three-deep history
    always @(posedge clk) begin
        ent_t e;
        if (rst) begin
            e = '{smp:0, scl:0, off:0, en:0, inv:0, nar:0, ob:0, vld:0, tag:1};
        end else begin
            e.smp = $signed(smp_data); e.scl = amp_scale; e.off = $signed(dc_offset);
            e.en = out_enable; e.inv = out_invert; e.nar = out_narrow; e.ob = out_offbin;
            e.vld = smp_valid; e.tag = cur_tag;
        end
        hist.push_back(e);
        if (hist.size() > 3) void'(hist.pop_front());
    end

    always @(negedge clk) begin
        if (!done && hist.size() == 3) begin
            int exp_c;
            exp_c = model_code(hist[0]);
            n_cmp++;
            if (dac_data !== 14'(exp_c) || dac_valid !== hist[0].vld) begin
                n_bad++;
                $display("FAIL R%0d: data=%h valid=%b expected data=%h valid=%b",
                         hist[0].tag, dac_data, dac_valid, 14'(exp_c), hist[0].vld);
            end
            if (dac_valid !== hist[0].vld && hist[0].tag != 2)
                $display("  (valid path R2 also implicated)");
        end
    end

    task automatic put(input int smp, input int scl, input int off,
                       input bit en, input bit inv, input bit nar, input bit ob,
                       input bit vld, input int tag);
        @(negedge clk);
        smp_data = 14'(smp); amp_scale = 16'(scl); dc_offset = 14'(off);
        out_enable = en; out_invert = inv; out_narrow = nar; out_offbin = ob;
        smp_valid = vld; cur_tag = tag;
    endtask

    function automatic int rnd_smp();
        return int'($urandom_range(16383, 0)) - 8192;
    endfunction

    initial begin
        // R1: reset state observed while reset is held
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R3: scale sweep, unity clip above 0x8000
        put(8191, 32768, 0, 1, 0, 0, 0, 1, 3);
        put(-8192, 32768, 0, 1, 0, 0, 0, 1, 3);
        put(-8192, 65535, 0, 1, 0, 0, 0, 1, 3);
        put(-1, 16384, 0, 1, 0, 0, 0, 1, 3);
        put(5000, 12345, 0, 1, 0, 0, 0, 1, 3);
        put(-3333, 40000, 0, 1, 0, 0, 0, 1, 3);
        // R4: bias with saturation on both rails
        put(8000, 32768, 1000, 1, 0, 0, 0, 1, 4);
        put(-8000, 32768, -1000, 1, 0, 0, 0, 1, 4);
        put(100, 32768, -50, 1, 0, 0, 0, 1, 4);
        put(8191, 32768, 8191, 1, 0, 0, 0, 1, 4);
        // R5: pure DC level
        put(7777, 0, 1234, 1, 0, 0, 0, 1, 5);
        put(-7777, 0, -4321, 1, 0, 0, 1, 1, 5);
        put(0, 0, 8191, 1, 0, 0, 0, 1, 5);
        // R6: polarity negate, most negative becomes most positive
        put(-8192, 32768, 0, 1, 1, 0, 0, 1, 6);
        put(1234, 32768, 0, 1, 1, 0, 0, 1, 6);
        put(8191, 32768, 0, 1, 1, 0, 0, 1, 6);
        // R7: rounding to 12 bits, overflow clamp
        put(8191, 32768, 0, 1, 0, 1, 0, 1, 7);
        put(8190, 32768, 0, 1, 0, 1, 0, 1, 7);
        put(-8192, 32768, 0, 1, 0, 1, 0, 1, 7);
        put(5, 32768, 0, 1, 0, 1, 0, 1, 7);
        put(-3, 32768, 0, 1, 0, 1, 0, 1, 7);
        // R6 with R4 and R7 in one sample: clamp, negate, round overflow
        put(-8192, 32768, -8192, 1, 1, 1, 0, 1, 6);
        put(-8192, 32768, -8192, 1, 1, 1, 1, 1, 6);
        // R8: offset binary coding
        put(-8192, 32768, 0, 1, 0, 0, 1, 1, 8);
        put(8191, 32768, 0, 1, 0, 0, 1, 1, 8);
        put(0, 32768, 0, 1, 0, 0, 1, 1, 8);
        // R9: mid-scale idle in both codings
        put(6000, 32768, 500, 0, 0, 0, 1, 1, 9);
        put(6000, 32768, 500, 0, 1, 1, 0, 1, 9);
        put(-6000, 20000, 0, 0, 0, 0, 1, 0, 9);
        // R2: valid strobe patterns
        for (int i = 0; i < 40; i++)
            put(rnd_smp(), 32768, 0, 1, 0, 0, 0, (i % 3 == 0) || (i % 7 == 1), 2);
        // R10: settings change every cycle
        for (int i = 0; i < 3000; i++)
            put(rnd_smp(), int'($urandom_range(40000, 0)), rnd_smp(),
                $urandom_range(3, 0) != 0, $urandom_range(1, 0) == 1,
                $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
                $urandom_range(1, 0) == 1, 10);
        put(0, 0, 0, 0, 0, 0, 0, 0, 10);
        repeat (4) @(negedge clk);
        // R1: reset again mid-stream
        put(8191, 32768, 100, 1, 0, 0, 1, 1, 1);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R2: watchdog expired, actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule